// File: doc/BRIEF.md
# Length-Prefixed Download Write Controller

This controller accepts a stream of received bytes, each announced by a ready strobe. It stores the payload of that stream in a byte-wide memory. The stream opens with a two-byte header that gives the payload size in bytes, most significant byte first. The controller captures this size. It then writes exactly that many following bytes to consecutive memory addresses, starting at address zero. When the last byte is stored, it holds an interrupt request to a processor until the request is acknowledged.

The acknowledge input also works as a restart. In any state it returns the controller to header capture, so a broken transfer can be abandoned and a new one started. The ready strobe is edge-detected, so a strobe held high for several cycles counts as one byte.

The controller has four states. `ST_LEN_HI` captures the upper size byte and clears the address counter, then goes to `ST_LEN_LO`. `ST_LEN_LO` captures the lower size byte. From there it goes to `ST_NOTIFY` if the size is zero, and to `ST_STORE` otherwise. `ST_STORE` writes one payload byte per strobe and decrements the remaining count. It goes to `ST_NOTIFY` on the write that makes the count zero. `ST_NOTIFY` raises the interrupt and stays put until acknowledge. Acknowledge moves any state to `ST_LEN_HI`.

Top module: `dl_write_ctrl`

## Requirements
- R1: After reset `irq` is 0 and `mem_we` is 0, and the first strobed byte is taken as the upper size byte.
- R2: The first strobed byte is bits 15:8 of the payload size and the second is bits 7:0. No memory write happens for either header byte.
- R3: Payload byte k of a transfer (k counting from 0) is written with `mem_addr` equal to k modulo 2^ADDR_W and `mem_data` equal to that byte.
- R4: Each rising edge of `rx_ready` produces exactly one write, however long `rx_ready` stays high. `mem_we` is high for one cycle, in the cycle after the edge in which `rx_ready` is first seen high.
- R5: A transfer of size N>0 produces exactly N writes. `irq` rises in the same cycle as the pulse of the N-th write.
- R6: A size of zero produces no write, and `irq` rises in the cycle after the second header byte is sampled.
- R7: `irq` stays high until `irq_ack` is sampled high. Strobes that arrive while `irq` is high cause no write and leave `irq` high.
- R8: `irq_ack` sampled high in any state clears `irq` in the next cycle and returns the controller to header capture, with the next payload starting at address 0. A strobe sampled in the same cycle as `irq_ack` is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | DATA_W | Received byte, valid while `rx_ready` is high |
| rx_ready | input | 1 | Byte-ready strobe; its rising edge marks a new byte |
| irq_ack | input | 1 | Interrupt acknowledge and restart |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable, one-cycle pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
Two events can land in the same cycle. One is the final payload write together with the rise of `irq`. The bench checks every write pulse for `irq` low, except the last of a transfer, where `irq` must already be high. It does this across a sweep of sizes, strobe hold lengths and gaps, including a size of 300 bytes, which wraps the 8-bit address of the small configuration under test. The other coincidence is acknowledge together with a strobe. The bench raises both in one cycle while `irq` is high, then sends a fresh header. A correct result (the right write count, addresses from zero, and `irq` at the final write) shows that the coincident byte was discarded and not taken as a size byte.

// File: rtl/dl_pkg.sv
package dl_pkg;

    typedef enum logic [1:0] {
        ST_LEN_HI = 2'd0,
        ST_LEN_LO = 2'd1,
        ST_STORE  = 2'd2,
        ST_NOTIFY = 2'd3
    } dl_state_t;

endpackage

// File: rtl/dl_strobe_edge.sv
module dl_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_pulse
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level_in;
        end
    end

    assign rise_pulse = level_in & ~level_q;

    assert_rise_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/dl_len_counter.sv
module dl_len_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              load_upper,
    input  logic              load_lower,
    input  logic              step_down,
    output logic              hdr_zero,
    output logic              at_last
);

    localparam int LEN_W = 2 * DATA_W;

    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_upper) begin
            remain_q[LEN_W-1:DATA_W] <= byte_in;
        end else if (load_lower) begin
            remain_q[DATA_W-1:0] <= byte_in;
        end else if (step_down) begin
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    assign hdr_zero = (remain_q[LEN_W-1:DATA_W] == '0) && (byte_in == '0);
    assign at_last  = (remain_q == LEN_W'(1));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_down |-> (remain_q != '0));

endmodule

// File: rtl/dl_addr_counter.sv
module dl_addr_counter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (advance) begin
            addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/dl_fsm.sv
module dl_fsm
    import dl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_strobe,
    input  logic      restart,
    input  logic      hdr_zero,
    input  logic      at_last,
    output dl_state_t state,
    output logic      load_upper,
    output logic      load_lower,
    output logic      store,
    output logic      addr_clear
);

    dl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LEN_HI;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d    = state;
        load_upper = 1'b0;
        load_lower = 1'b0;
        store      = 1'b0;
        addr_clear = 1'b0;
        if (restart) begin
            state_d = ST_LEN_HI;
        end else begin
            unique case (state)
                ST_LEN_HI: begin
                    if (byte_strobe) begin
                        load_upper = 1'b1;
                        addr_clear = 1'b1;
                        state_d    = ST_LEN_LO;
                    end
                end
                ST_LEN_LO: begin
                    if (byte_strobe) begin
                        load_lower = 1'b1;
                        state_d    = hdr_zero ? ST_NOTIFY : ST_STORE;
                    end
                end
                ST_STORE: begin
                    if (byte_strobe) begin
                        store   = 1'b1;
                        state_d = at_last ? ST_NOTIFY : ST_STORE;
                    end
                end
                ST_NOTIFY: begin
                    state_d = ST_NOTIFY;
                end
                default: state_d = ST_LEN_HI;
            endcase
        end
    end

    assert_restart_to_header_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_LEN_HI));

    assert_notify_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOTIFY && !restart) |=> (state == ST_NOTIFY));

endmodule

// File: rtl/dl_write_ctrl.sv
module dl_write_ctrl
    import dl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ready,
    input  logic              irq_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    output logic              irq
);

    logic              byte_strobe;
    logic              hdr_zero;
    logic              at_last;
    logic              load_upper;
    logic              load_lower;
    logic              store;
    logic              addr_clear;
    logic [ADDR_W-1:0] next_addr;
    dl_state_t         state;

    dl_strobe_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_in   (rx_ready),
        .rise_pulse (byte_strobe)
    );

    dl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_strobe (byte_strobe),
        .restart     (irq_ack),
        .hdr_zero    (hdr_zero),
        .at_last     (at_last),
        .state       (state),
        .load_upper  (load_upper),
        .load_lower  (load_lower),
        .store       (store),
        .addr_clear  (addr_clear)
    );

    dl_len_counter #(.DATA_W(DATA_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (rx_byte),
        .load_upper (load_upper),
        .load_lower (load_lower),
        .step_down  (store),
        .hdr_zero   (hdr_zero),
        .at_last    (at_last)
    );

    dl_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_clear),
        .advance (store),
        .addr    (next_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= store;
            if (store) begin
                mem_addr <= next_addr;
                mem_data <= rx_byte;
            end
        end
    end

    assign irq = (state == ST_NOTIFY);

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq && !mem_we));

    assert_no_write_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !mem_we);

endmodule

// File: tb/dl_write_ctrl_test.sv
`timescale 1ns/1ps
module dl_write_ctrl_test;

    localparam int DW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_ready = 1'b0;
    logic          irq_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_we;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int exp_len = 0;
    logic [7:0] payload [0:511];

    always #2 clk = ~clk;

    dl_write_ctrl #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .irq_ack(irq_ack), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_we(mem_we), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // write monitor: R3 address/data, R5 irq coincident with last write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            check(mem_addr === AW'(wr_count), "R3 addr", int'(mem_addr), wr_count % 256);
            check(mem_data === payload[wr_count], "R3 data", int'(mem_data), int'(payload[wr_count]));
            check(irq === (wr_count == exp_len - 1), "R5 irq at last write", int'(irq),
                  int'(wr_count == exp_len - 1));
            wr_count++;
        end
    end

    task automatic send_byte(input logic [7:0] b, input int hold, input int gap);
        @(negedge clk);
        rx_byte  = b;
        rx_ready = 1'b1;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk);
        rx_ready = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic begin_xfer(input int len, input int seed);
        for (int i = 0; i < 512; i++) payload[i] = 8'(i * 7 + seed * 13 + 5);
        @(posedge clk);
        wr_count = 0;
        exp_len  = len;
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq === 1'b0, "R8 ack clears irq", int'(irq), 0);
    endtask

    task automatic run_xfer(input int len, input int seed, input int hmax);
        begin_xfer(len, seed);
        send_byte(8'(len >> 8), 1 + seed % hmax, 1);
        send_byte(8'(len), 1 + (seed + 1) % hmax, 2);
        check(wr_count == 0, "R2 no header write", wr_count, 0);
        for (int i = 0; i < len; i++)
            send_byte(payload[i], 1 + (i + seed) % hmax, 1 + i % 2);
        @(negedge clk);
        check(wr_count == len, "R5 write count", wr_count, len);
        check(irq === 1'b1, "R5 irq after transfer", int'(irq), 1);
        // R7: strobe during notify is ignored
        send_byte(8'hC3, 2, 2);
        check(wr_count == len, "R7 no write in notify", wr_count, len);
        check(irq === 1'b1, "R7 irq held", int'(irq), 1);
        do_ack();
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq === 1'b0, "R1 irq reset", int'(irq), 0);
        check(mem_we === 1'b0, "R1 we reset", int'(mem_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(irq === 1'b0 && mem_we === 1'b0, "R1 idle after reset", int'(irq), 0);

        // R6: zero length, irq exactly one cycle after second header byte
        begin_xfer(0, 1);
        send_byte(8'h00, 1, 1);
        @(negedge clk);
        rx_byte = 8'h00; rx_ready = 1'b1;
        check(irq === 1'b0, "R6 irq not early", int'(irq), 0);
        @(negedge clk);
        rx_ready = 1'b0;
        check(irq === 1'b1, "R6 irq after zero header", int'(irq), 1);
        check(wr_count == 0, "R6 no writes", wr_count, 0);
        do_ack();

        // R2/R3/R4/R5 sweep over sizes, hold lengths and gaps
        for (int n = 1; n <= 20; n++) run_xfer(n, n, 3);
        run_xfer(7, 2, 6);          // R4 long holds
        run_xfer(300, 9, 2);        // R2 upper byte nonzero, R3 address wrap

        // R8: restart mid-payload, next transfer starts at address 0
        begin_xfer(10, 4);
        send_byte(8'h00, 1, 1);
        send_byte(8'h0A, 1, 1);
        for (int i = 0; i < 3; i++) send_byte(payload[i], 2, 1);
        check(wr_count == 3, "R8 partial writes", wr_count, 3);
        do_ack();
        run_xfer(4, 5, 2);

        // R8: restart during header
        begin_xfer(0, 6);
        send_byte(8'h01, 1, 1);
        do_ack();
        run_xfer(3, 6, 2);

        // R8: ack and strobe in the same cycle while irq is high
        begin_xfer(1, 7);
        send_byte(8'h00, 1, 1);
        send_byte(8'h01, 1, 1);
        send_byte(payload[0], 1, 1);
        @(negedge clk);
        check(irq === 1'b1, "R5 irq single byte", int'(irq), 1);
        irq_ack = 1'b1; rx_byte = 8'hAA; rx_ready = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; rx_ready = 1'b0;
        check(irq === 1'b0, "R8 ack with strobe", int'(irq), 0);
        run_xfer(2, 8, 2);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule